// File: doc/BRIEF.md
# Write-Back Set-Associative Data Cache

A data cache placed between a core load/store port and a backing memory that moves whole lines. It keeps 32 KB in four ways of 256 sets, each line 32 bytes (eight 32-bit words). Stores allocate on a miss and mark the line dirty. A dirty line goes back to memory only when it is chosen as a victim or when a maintenance request targets it. Each set keeps a true least-recently-used order.

Besides loads and stores, the core port accepts two index-addressed maintenance requests. These name a way and a set straight from address bits and ignore the tag. One writes a dirty line back and then drops it. The other drops the line and never writes it back. A cache full of dirty lines can be emptied in either of two ways: by streaming reads that force every original line out through replacement, or by walking the index requests over every way and set.

Top module: `dcache_wb`

## Requirements
- R1: Address fields. Bits [4:2] select the word in the line, bits [12:5] select the set, and bits [31:13] form the tag. A line fetched for one address supplies every other word of that line.
- R2: Reset state. While rst_ni is low and after it is released, busy_o, rsp_valid_o and mem_req_o are low and every line is invalid, so the first load misses.
- R3: Request codes on req_op_i are 0 load, 1 store, 2 index write-back-invalidate and 3 index invalidate. A request is taken at a rising edge where req_valid_i is high and busy_o is low. On a hit, rsp_valid_o rises one cycle after acceptance, lasts exactly one cycle, and there is no memory traffic.
- R4: A load miss issues one line read: mem_req_o high, mem_we_o low, mem_addr_o the line address with bits [4:0] zero. It then responds with the requested word of the fetched line.
- R5: Stores write-allocate. A store hit updates the word, sets the line dirty and causes no memory traffic. A later load of that word returns the stored value.
- R6: The victim on a miss is the lowest-numbered invalid way of the set if there is one. Otherwise it is the least recently used way. Hits and fills count as uses.
- R7: A valid dirty victim is written back as a full line (mem_we_o high, mem_addr_o its own line address) before the fill read is issued. The written data is what a later refetch returns.
- R8: After every line has been dirtied, loads over four times the capacity at a 32-byte stride write back each dirty line exactly once and leave no dirty line resident.
- R9: Index write-back-invalidate selects the way with bits [14:13] and the set with bits [12:5]. It writes that line back only if it is valid and dirty, then invalidates it and gives one response. It never reads memory.
- R10: Index invalidate clears the selected line with no write-back. Stored data that was never written back is lost, and the next load refetches from memory.
- R11: Index requests walked over addresses 0x0000 to 0x7FFF in 32-byte steps reach every line, so every line resident before the walk misses afterwards.
- R12: busy_o is high from the cycle after acceptance until the response cycle. A request presented while busy_o is high is ignored.
- R13: Once mem_req_o rises, it stays high with mem_addr_o and mem_we_o unchanged until the edge where mem_ack_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request present |
| req_op_i | input | 2 | Request code: 0 load, 1 store, 2 index write-back-invalidate, 3 index invalidate |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Store data (full word) |
| busy_o | output | 1 | Cache occupied; requests are not taken |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 32 | Load data, valid with rsp_valid_o |
| mem_req_o | output | 1 | Line transfer request to memory |
| mem_we_o | output | 1 | 1 for line write-back, 0 for line fill |
| mem_addr_o | output | 32 | Line-aligned memory address |
| mem_wdata_o | output | 256 | Line written back |
| mem_ack_i | input | 1 | Memory completes the transfer at this edge |
| mem_rdata_i | input | 256 | Fill data, valid with mem_ack_i |

## Verification
The hardest state to reach from the ports is a cache in which all 1024 lines are dirty at once and the four lines of each set are then pushed out purely by replacement order. The stimulus first stores to every line address of the capacity. It then streams 4096 loads at a 32-byte stride, counting write-backs, and follows with an index write-back-invalidate walk that must find nothing dirty. Victim selection inside one set is driven by a fixed vector table. Its eviction order, including refetches of data that was written back earlier, is worked out by hand.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [1:0] {
    OP_LOAD      = 2'd0,
    OP_STORE     = 2'd1,
    OP_IDX_WBINV = 2'd2,
    OP_IDX_INV   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_INV
  } state_e;

endpackage

// File: rtl/dcache_way.sv
module dcache_way #(
  parameter  int unsigned SETS   = 256,
  parameter  int unsigned TAG_W  = 19,
  parameter  int unsigned WORDS  = 8,
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned SEL_W  = $clog2(WORDS),
  localparam int unsigned LINE_W = WORDS * 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              fill_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              store_i,
  input  logic [SEL_W-1:0]  store_sel_i,
  input  logic [31:0]       store_data_i,
  input  logic              inval_i,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [LINE_W-1:0] line_o
);

  logic [LINE_W-1:0] data_q [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [SETS-1:0]   valid_q, dirty_q;
  logic [SEL_W+4:0]  bit_base;

  assign bit_base = {store_sel_i, 5'd0};

  // payload: no reset needed, guarded by valid_q
  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      data_q[idx_i] <= fill_line_i;
      tag_q[idx_i]  <= fill_tag_i;
    end else if (store_i) begin
      data_q[idx_i][bit_base +: 32] <= store_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (store_i) begin
      dirty_q[idx_i] <= 1'b1;
    end else if (inval_i) begin
      valid_q[idx_i] <= 1'b0;
      dirty_q[idx_i] <= 1'b0;
    end
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
  assign line_o  = data_q[idx_i];

  p_single_cmd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fill_i, store_i, inval_i}));

  p_store_resident_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i |-> valid_o);

  p_store_dirty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i |=> (!$stable(idx_i) || dirty_o));

  p_fill_clean_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> (!$stable(idx_i) || (valid_o && !dirty_o)));

  p_inval_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> (!$stable(idx_i) || (!valid_o && !dirty_o)));

endmodule

// File: rtl/dcache_lru.sv
module dcache_lru #(
  parameter  int unsigned SETS  = 256,
  parameter  int unsigned WAYS  = 4,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o
);

  // age 0 = most recent, WAYS-1 = least recent; ages form a permutation per set
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  oldest_vec;
  logic [WAY_W-1:0] inv_way, old_way;
  logic             any_inv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i) begin
          age_q[idx_i][w] <= '0;
        end else if (age_q[idx_i][w] < age_q[idx_i][touch_way_i]) begin
          age_q[idx_i][w] <= age_q[idx_i][w] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    inv_way = '0;
    old_way = '0;
    any_inv = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      oldest_vec[w] = (age_q[idx_i][w] == WAY_W'(WAYS - 1));
      if (!valid_i[w]) begin
        inv_way = WAY_W'(w);
        any_inv = 1'b1;
      end
      if (oldest_vec[w]) old_way = WAY_W'(w);
    end
    victim_o = any_inv ? inv_way : old_way;
  end

  p_lru_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest_vec) == 1);

  p_touch_young_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (touch_i && &valid_i) |=> (!$stable(idx_i) || victim_o != $past(touch_way_i)));

endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
  import dcache_pkg::*;
#(
  parameter  int unsigned ADDR_W     = 32,
  parameter  int unsigned WAYS       = 4,
  parameter  int unsigned SETS       = 256,
  parameter  int unsigned LINE_WORDS = 8,
  localparam int unsigned SEL_W      = $clog2(LINE_WORDS),
  localparam int unsigned OFF_W      = SEL_W + 2,
  localparam int unsigned IDX_W      = $clog2(SETS),
  localparam int unsigned WAY_W      = $clog2(WAYS),
  localparam int unsigned TAG_W      = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned LINE_W     = LINE_WORDS * 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [LINE_W-1:0] mem_rdata_i
);

  state_e              state_q, state_d;
  op_e                 op_q;
  logic [ADDR_W-1:2]   addr_q;
  logic [31:0]         wdata_q;
  logic [WAY_W-1:0]    way_q, way_d;
  logic                rsp_valid_q;
  logic [31:0]         rsp_rdata_q;
  logic                unused_addr;

  logic [IDX_W-1:0]    idx;
  logic [SEL_W-1:0]    sel;
  logic [TAG_W-1:0]    tag;
  logic [WAY_W-1:0]    ix_way;
  logic                is_idx;

  logic [TAG_W-1:0]    w_tag  [WAYS];
  logic [LINE_W-1:0]   w_line [WAYS];
  logic [WAYS-1:0]     w_valid, w_dirty, w_fill, w_store, w_inval, hit_vec;
  logic                hit;
  logic [WAY_W-1:0]    hit_way, victim;
  logic [LINE_W-1:0]   hit_line;
  logic [SEL_W+4:0]    bit_base;
  logic [31:0]         hit_word;

  logic                fill_en, store_en, inval_en, touch, rsp_set;

  assign unused_addr = ^req_addr_i[1:0];

  assign idx    = addr_q[OFF_W +: IDX_W];
  assign sel    = addr_q[2 +: SEL_W];
  assign tag    = addr_q[ADDR_W-1 -: TAG_W];
  assign ix_way = addr_q[OFF_W + IDX_W +: WAY_W];
  assign is_idx = (op_q == OP_IDX_WBINV) || (op_q == OP_IDX_INV);

  // ---------------- way storage ----------------
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign w_fill[g]  = fill_en  && (way_q   == WAY_W'(g));
    assign w_store[g] = store_en && (hit_way == WAY_W'(g));
    assign w_inval[g] = inval_en && (way_q   == WAY_W'(g));
    assign hit_vec[g] = w_valid[g] && (w_tag[g] == tag);

    dcache_way #(
      .SETS  (SETS),
      .TAG_W (TAG_W),
      .WORDS (LINE_WORDS)
    ) i_way (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .idx_i        (idx),
      .fill_i       (w_fill[g]),
      .fill_tag_i   (tag),
      .fill_line_i  (mem_rdata_i),
      .store_i      (w_store[g]),
      .store_sel_i  (sel),
      .store_data_i (wdata_q),
      .inval_i      (w_inval[g]),
      .valid_o      (w_valid[g]),
      .dirty_o      (w_dirty[g]),
      .tag_o        (w_tag[g]),
      .line_o       (w_line[g])
    );
  end

  dcache_lru #(
    .SETS (SETS),
    .WAYS (WAYS)
  ) i_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (idx),
    .valid_i     (w_valid),
    .touch_i     (touch),
    .touch_way_i (hit_way),
    .victim_o    (victim)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit      = |hit_vec;
  assign hit_line = w_line[hit_way];
  assign bit_base = {sel, 5'd0};
  assign hit_word = hit_line[bit_base +: 32];

  // ---------------- control ----------------
  always_comb begin
    state_d  = state_q;
    way_d    = way_q;
    fill_en  = 1'b0;
    store_en = 1'b0;
    inval_en = 1'b0;
    touch    = 1'b0;
    rsp_set  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) state_d = ST_LOOK;
      end
      ST_LOOK: begin
        if (is_idx) begin
          way_d = ix_way;
          if (op_q == OP_IDX_WBINV && w_valid[ix_way] && w_dirty[ix_way]) state_d = ST_WB;
          else                                                            state_d = ST_INV;
        end else if (hit) begin
          touch    = 1'b1;
          store_en = (op_q == OP_STORE);
          rsp_set  = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          way_d = victim;
          if (w_valid[victim] && w_dirty[victim]) state_d = ST_WB;
          else                                    state_d = ST_FILL;
        end
      end
      ST_WB: begin
        if (mem_ack_i) state_d = is_idx ? ST_INV : ST_FILL;
      end
      ST_FILL: begin
        if (mem_ack_i) begin
          fill_en = 1'b1;
          state_d = ST_LOOK;  // re-lookup hits and merges a store
        end
      end
      ST_INV: begin
        inval_en = 1'b1;
        rsp_set  = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_LOAD;
      addr_q      <= '0;
      wdata_q     <= '0;
      way_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      state_q     <= state_d;
      way_q       <= way_d;
      rsp_valid_q <= rsp_set;
      if (rsp_set) rsp_rdata_q <= is_idx ? 32'd0 : hit_word;
      if (state_q == ST_IDLE && req_valid_i) begin
        op_q    <= op_e'(req_op_i);
        addr_q  <= req_addr_i[ADDR_W-1:2];
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign mem_req_o   = (state_q == ST_WB) || (state_q == ST_FILL);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = (state_q == ST_WB) ? {w_tag[way_q], idx, {OFF_W{1'b0}}}
                                          : {tag, idx, {OFF_W{1'b0}}};
  assign mem_wdata_o = w_line[way_q];

  // ---------------- assertions ----------------
  p_wb_dirty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (w_valid[way_q] && w_dirty[way_q]));

  p_fill_miss_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> !hit);

  p_idx_wr_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && is_idx) |-> mem_we_o);

  p_req_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_rsp_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !busy_o);

  p_rsp_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

endmodule

// File: tb/test_dcache_wb.sv
`timescale 1ns/1ps
module test_dcache_wb;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i;
  logic [1:0]   req_op_i;
  logic [31:0]  req_addr_i;
  logic [31:0]  req_wdata_i;
  logic         busy_o, rsp_valid_o, mem_req_o, mem_we_o;
  logic [31:0]  rsp_rdata_o, mem_addr_o;
  logic [255:0] mem_wdata_o, mem_rdata_i;
  logic         mem_ack_i;

  dcache_wb i_dcache_wb (
    .clk_i, .rst_ni, .req_valid_i, .req_op_i, .req_addr_i, .req_wdata_i,
    .busy_o, .rsp_valid_o, .rsp_rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );

  always #4 clk_i = ~clk_i;  // 125 MHz

  int n_chk = 0, n_err = 0;
  int fill_cnt = 0, wb_cnt = 0, txn_cnt = 0, rsp_cnt = 0;
  logic first_we = 1'b0;
  logic [31:0] last_wb = '0;
  bit hold_bad = 1'b0;

  logic [255:0] mem [4096];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // backing memory: word at byte address a holds A5000000 ^ a
  initial begin
    for (int l = 0; l < 4096; l++)
      for (int w = 0; w < 8; w++)
        mem[l][w*32 +: 32] = 32'hA500_0000 ^ ((l << 5) | (w << 2));
  end

  always @(negedge clk_i) if (rsp_valid_o) rsp_cnt++;

  initial begin
    mem_ack_i   = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk_i);
      mem_ack_i = 1'b0;
      if (mem_req_o) begin
        logic [31:0] a;
        logic        we;
        a  = mem_addr_o;
        we = mem_we_o;
        repeat (2) begin
          @(negedge clk_i);
          if (!mem_req_o || mem_addr_o != a || mem_we_o != we) hold_bad = 1'b1;
        end
        if (txn_cnt == 0) first_we = we;
        txn_cnt++;
        if (we) begin
          mem[a[16:5]] = mem_wdata_o;
          wb_cnt++;
          last_wb = a;
        end else begin
          mem_rdata_i = mem[a[16:5]];
          fill_cnt++;
        end
        mem_ack_i = 1'b1;
      end
    end
  end

  task automatic do_op(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] wd,
                       output logic [31:0] rd, output int lat, output logic busy1);
    @(negedge clk_i);
    fill_cnt = 0; wb_cnt = 0; txn_cnt = 0; first_we = 1'b0;
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = addr; req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    busy1 = busy_o;
    lat = 1;
    while (!rsp_valid_o && lat < 300) begin
      @(negedge clk_i);
      lat++;
    end
    rd = rsp_rdata_o;
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] wd;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  fills;
    logic [3:0]  wbs;
  } vec_t;

  // all in set 0; tag = addr[16:13]
  localparam vec_t VECS [20] = '{
    '{2'd0, 32'h0000_0004, 32'h0, 1'b1, 32'hA500_0004, 4'd1, 4'd0}, // R2 R4 cold miss
    '{2'd0, 32'h0000_0008, 32'h0, 1'b1, 32'hA500_0008, 4'd0, 4'd0}, // R1 same line
    '{2'd1, 32'h0000_000C, 32'h1111_1111, 1'b0, 32'h0, 4'd0, 4'd0}, // R5 store hit
    '{2'd0, 32'h0000_000C, 32'h0, 1'b1, 32'h1111_1111, 4'd0, 4'd0},
    '{2'd1, 32'h0000_2010, 32'h2222_2222, 1'b0, 32'h0, 4'd1, 4'd0}, // R5 allocate
    '{2'd0, 32'h0000_2010, 32'h0, 1'b1, 32'h2222_2222, 4'd0, 4'd0},
    '{2'd0, 32'h0000_2000, 32'h0, 1'b1, 32'hA500_2000, 4'd0, 4'd0},
    '{2'd0, 32'h0000_4000, 32'h0, 1'b1, 32'hA500_4000, 4'd1, 4'd0},
    '{2'd0, 32'h0000_6000, 32'h0, 1'b1, 32'hA500_6000, 4'd1, 4'd0},
    '{2'd0, 32'h0000_8000, 32'h0, 1'b1, 32'hA500_8000, 4'd1, 4'd1}, // R6 R7 evict tag0
    '{2'd0, 32'h0000_000C, 32'h0, 1'b1, 32'h1111_1111, 4'd1, 4'd1}, // R7 refetch, evict tag1
    '{2'd0, 32'h0000_2010, 32'h0, 1'b1, 32'h2222_2222, 4'd1, 4'd0}, // R6 clean victim
    '{2'd1, 32'h0000_0000, 32'hA0A0_A0A0, 1'b0, 32'h0, 4'd0, 4'd0},
    '{2'd2, 32'h0000_2000, 32'h0, 1'b0, 32'h0, 4'd0, 4'd1},          // R9 way1 dirty
    '{2'd0, 32'h0000_0000, 32'h0, 1'b1, 32'hA0A0_A0A0, 4'd1, 4'd0}, // R6 invalid way first
    '{2'd1, 32'h0000_2004, 32'h5555_5555, 1'b0, 32'h0, 4'd0, 4'd0},
    '{2'd3, 32'h0000_4000, 32'h0, 1'b0, 32'h0, 4'd0, 4'd0},          // R10 drop way2
    '{2'd0, 32'h0000_2004, 32'h0, 1'b1, 32'hA500_2004, 4'd1, 4'd0}, // R10 store lost
    '{2'd2, 32'h0000_0000, 32'h0, 1'b0, 32'h0, 4'd0, 4'd0},          // R9 clean: no wb
    '{2'd0, 32'h0000_8000, 32'h0, 1'b1, 32'hA500_8000, 4'd1, 4'd0}  // R9 line gone
  };

  initial begin
    repeat (150000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat, bad, r0;
    logic b1;
    req_valid_i = 1'b0; req_op_i = '0; req_addr_i = '0; req_wdata_i = '0;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !rsp_valid_o && !mem_req_o, "R2 outputs in reset",
          {busy_o, rsp_valid_o, mem_req_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !rsp_valid_o && !mem_req_o, "R2 outputs after reset",
          {busy_o, rsp_valid_o, mem_req_o}, 32'd0);

    for (int i = 0; i < 20; i++) begin
      do_op(VECS[i].op, VECS[i].addr, VECS[i].wd, rd, lat, b1);
      if (VECS[i].chk) check(rd == VECS[i].exp, "R1 R4 R5 load data", rd, VECS[i].exp);
      check(fill_cnt == int'(VECS[i].fills), "R4 R6 R10 fill count", fill_cnt, VECS[i].fills);
      check(wb_cnt == int'(VECS[i].wbs), "R7 R9 R10 write-back count", wb_cnt, VECS[i].wbs);
      if (VECS[i].wbs != 0 && VECS[i].op < 2'd2)
        check(first_we == 1'b1, "R7 write-back precedes fill", first_we, 1);
      if (i == 9) check(last_wb == 32'h0, "R7 victim line address", last_wb, 32'h0);
    end

    // R3: hit latency and pulse width
    do_op(2'd0, 32'h0000_8004, '0, rd, lat, b1);
    check(lat == 2, "R3 hit response cycle", lat, 2);
    check(b1 == 1'b1, "R12 busy after acceptance", b1, 1);
    check(fill_cnt == 0 && wb_cnt == 0, "R3 hit no traffic", fill_cnt + wb_cnt, 0);
    @(negedge clk_i);
    check(!rsp_valid_o, "R3 single-cycle response", rsp_valid_o, 0);

    // R12: request held during a miss is ignored
    r0 = rsp_cnt;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = 2'd0; req_addr_i = 32'h0000_0040;
    @(negedge clk_i);
    req_op_i = 2'd1; req_addr_i = 32'h0000_0060; req_wdata_i = 32'hDEAD_BEEF;
    lat = 0;
    while (!rsp_valid_o && lat < 300) begin @(negedge clk_i); lat++; end
    req_valid_i = 1'b0;
    check(rsp_valid_o && rsp_rdata_o == 32'hA500_0040, "R12 first request data", rsp_rdata_o, 32'hA500_0040);
    repeat (4) @(negedge clk_i);
    check(rsp_cnt - r0 == 1, "R12 one response only", rsp_cnt - r0, 1);
    do_op(2'd0, 32'h0000_0060, '0, rd, lat, b1);
    check(rd == 32'hA500_0060, "R12 ignored store", rd, 32'hA500_0060);

    // R8: dirty every line, then flood 128 KB
    for (int a = 0; a < 32'h8000; a += 32) do_op(2'd1, a, 32'hD000_0000 | a, rd, lat, b1);
    bad = 0; r0 = 0;
    for (int a = 0; a < 32'h20000; a += 32) begin
      do_op(2'd0, a, '0, rd, lat, b1);
      r0 += wb_cnt;
      if (rd != ((a < 32'h8000) ? (32'hD000_0000 | a) : (32'hA500_0000 ^ a))) bad++;
    end
    check(r0 == 1024, "R8 each dirty line written back once", r0, 1024);
    check(bad == 0, "R8 flood load data", bad, 0);

    // R11: index walk finds nothing dirty and clears every line
    r0 = 0;
    for (int a = 0; a < 32'h8000; a += 32) begin
      do_op(2'd2, a, '0, rd, lat, b1);
      r0 += wb_cnt;
    end
    check(r0 == 0, "R8 R9 no dirty line after flood", r0, 0);
    r0 = 0;
    for (int a = 32'h18000; a < 32'h20000; a += 32) begin
      do_op(2'd0, a, '0, rd, lat, b1);
      r0 += fill_cnt;
    end
    check(r0 == 1024, "R11 every line missed after walk", r0, 1024);
    do_op(2'd0, 32'h0000_0020, '0, rd, lat, b1);
    check(rd == 32'hD000_0020, "R7 R8 written-back data", rd, 32'hD000_0020);
    do_op(2'd0, 32'h0000_7FE0, '0, rd, lat, b1);
    check(rd == 32'hD000_7FE0, "R7 R8 written-back data", rd, 32'hD000_7FE0);

    check(!hold_bad, "R13 memory request held until ack", hold_bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule